// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire serial link to a successive-approximation converter. When a sample is requested, it pulls chip select low, waits a programmable setup interval, and then drives a burst of exactly sixteen serial clock periods. It shifts in one bit at each falling edge it generates.

Each frame starts with four zero bits. The result follows, most significant bit first. In the 10-bit build two padding bits close the frame. The block strips the framing bits and presents the result on a parallel bus with a one-cycle valid strobe. It flags a framing error when a leading bit is not zero. It then holds chip select high for a programmable quiet interval before another frame may start.

The serial clock comes from the system clock through an even divider, so its duty cycle is exactly half. The half period, the setup interval and the quiet interval are all counted in system clock cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select and the serial clock are both high, valid is low and ready is high.
- R2: A frame starts only from idle with the request high. Chip select goes low in the cycle after the request is sampled, and ready stays low until the frame and its quiet gap are over. With the request low, chip select stays high.
- R3: The first serial clock falling edge comes exactly SETUP_CYC system cycles after chip select falls.
- R4: While chip select is low, the serial clock has exactly 16 falling edges. Every high and every low phase between them lasts HALF_DIV system cycles. While chip select is high, the serial clock stays high.
- R5: One data bit is taken at each generated falling edge. The value taken is the one present just before that edge. The first bit taken is the one the converter presents from the chip select fall. Frame bit 0 is therefore the first bit on the wire, and frame bit 15 is the last.
- R6: With RES_BITS = 12, the result is frame bits 4 to 15. Frame bit 4 is the result MSB, and frame bit 15 is the LSB.
- R7: With RES_BITS = 10, the result is frame bits 4 to 13, MSB first. Frame bits 14 and 15, the padding, have no effect on the result.
- R8: The framing error output is 1 exactly when any of frame bits 0 to 3 is 1. The result is still delivered in that case. Both outputs hold until the next frame ends.
- R9: Valid is a single-cycle pulse. It is high in the same cycle that chip select returns high at the end of a frame.
- R10: Between the end of one frame and the next fall of chip select, chip select stays high for at least QUIET_CYC system cycles, even with the request held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Sample request, sampled while idle |
| ready_o | output | 1 | High when idle and able to start a frame |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | RES_BITS | Conversion result of the last frame |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| frame_err_o | output | 1 | A leading bit of the last frame was 1 |

## Verification
A bit counter that is off by one shows within a single frame. The frame then has 15 or 17 serial clock falls, and the result is shifted by one position, which shows up as a wrong value on the next valid strobe. A divider or sequencer fault shows within one serial clock period, as a phase length other than HALF_DIV or a setup interval other than SETUP_CYC. A stuck quiet counter shows at the second back-to-back frame, as a short chip select high gap. A bad extraction function shows on the first frame whose leading or padding bits are not zero.

// File: rtl/adc_frm_pkg.sv
package adc_frm_pkg;

  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int NB_W       = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_QUIET
  } frm_state_e;

  // any of the four leading bits set
  function automatic logic lead_bad(input logic [FRAME_BITS-1:0] w);
    return |w[FRAME_BITS-1 -: LEAD_BITS];
  endfunction

  // result bits that follow the leading zeros, right aligned
  function automatic logic [11:0] pick_result(input logic [FRAME_BITS-1:0] w,
                                              input int unsigned res_bits);
    if (res_bits == 10) return {2'b00, w[11:2]};
    return w[11:0];
  endfunction

endpackage

// File: rtl/adc_frm_halfdiv.sv
module adc_frm_halfdiv #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HW-1:0] cnt;

  assign half_tick = run && (cnt == HW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_frm_seq.sv
module adc_frm_seq
  import adc_frm_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic half_tick,
  output logic run,
  output logic cs_n,
  output logic sclk,
  output logic ready,
  output logic fall_evt,
  output logic frame_done
);
  localparam int CMAX = (SETUP_CYC > QUIET_CYC) ? SETUP_CYC : QUIET_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  frm_state_e      st;
  logic [CW-1:0]   cnt;
  logic [NB_W-1:0] nbits;
  logic            sclk_q;
  logic            setup_end, quiet_end, high_end;

  assign setup_end  = (st == ST_SETUP) && (cnt == CW'(SETUP_CYC - 1));
  assign quiet_end  = (st == ST_QUIET) && (cnt == CW'(QUIET_CYC - 1));
  assign high_end   = (st == ST_SHIFT) && half_tick && sclk_q;
  assign frame_done = high_end && (nbits == NB_W'(FRAME_BITS));
  assign fall_evt   = setup_end || (high_end && (nbits != NB_W'(FRAME_BITS)));

  assign run   = (st == ST_SHIFT);
  assign cs_n  = (st == ST_IDLE) || (st == ST_QUIET);
  assign ready = (st == ST_IDLE);
  assign sclk  = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      nbits  <= '0;
      sclk_q <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt   <= '0;
          nbits <= '0;
          if (req) st <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_end) begin
            st  <= ST_SHIFT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (half_tick && !sclk_q) sclk_q <= 1'b1;
          if (frame_done)           st     <= ST_QUIET;
        end
        default: begin
          if (quiet_end) st <= ST_IDLE;
          else           cnt <= cnt + 1'b1;
        end
      endcase
      if (fall_evt) begin
        sclk_q <= 1'b0;
        nbits  <= nbits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_frm_capture.sv
module adc_frm_capture
  import adc_frm_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata,
  input  logic                fall_evt,
  input  logic                frame_done,
  output logic [RES_BITS-1:0] sample,
  output logic                valid,
  output logic                ferr
);
  logic [FRAME_BITS-1:0] shreg;
  logic [11:0]           picked;

  assign picked = pick_result(shreg, RES_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sample <= '0;
      valid  <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      valid <= frame_done;
      if (fall_evt) shreg <= {shreg[FRAME_BITS-2:0], sdata};
      if (frame_done) begin
        sample <= picked[RES_BITS-1:0];
        ferr   <= lead_bad(shreg);
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int HALF_DIV  = 3,
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4,
  parameter int RES_BITS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  output logic                ready_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  input  logic                sdata_i,
  output logic [RES_BITS-1:0] sample_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  // named internal events
  logic run_w;
  logic half_tick_w;
  logic fall_evt_w;
  logic frame_done_w;

  adc_frm_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .half_tick (half_tick_w)
  );

  adc_frm_seq #(.SETUP_CYC(SETUP_CYC), .QUIET_CYC(QUIET_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_i),
    .half_tick  (half_tick_w),
    .run        (run_w),
    .cs_n       (cs_n_o),
    .sclk       (sclk_o),
    .ready      (ready_o),
    .fall_evt   (fall_evt_w),
    .frame_done (frame_done_w)
  );

  adc_frm_capture #(.RES_BITS(RES_BITS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdata      (sdata_i),
    .fall_evt   (fall_evt_w),
    .frame_done (frame_done_w),
    .sample     (sample_o),
    .valid      (valid_o),
    .ferr       (frame_err_o)
  );
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic ready_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o,
  input logic fall_evt,
  input logic frame_done
);
  logic [15:0] lo_cnt, hi_cnt;
  logic [4:0]  nf;
  logic        sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      hi_cnt    <= 16'(QUIET_CYC);
      nf        <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_o;
      if (cs_n_o) begin
        lo_cnt <= '0;
        nf     <= '0;
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        if (sclk_prev && !sclk_o) nf <= nf + 1'b1;
      end
    end
  end

  a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  a_r2_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(req_i) && $past(ready_o)));

  a_r3_setup_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && nf == 5'd0) |-> (lo_cnt == 16'(SETUP_CYC)));

  a_r4_sclk_moves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> !cs_n_o);

  a_r4_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (nf == 5'd16));

  a_r5_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> $fell(sclk_o));

  a_r9_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r9_done_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> valid_o);

  a_r10_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= 16'(QUIET_CYC)));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .SETUP_CYC (SETUP_CYC),
  .QUIET_CYC (QUIET_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .valid_o    (valid_o),
  .fall_evt   (fall_evt_w),
  .frame_done (frame_done_w)
);

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] word,
  output logic        sdata
);
  logic [15:0] held;
  int          idx;
  initial begin sdata = 1'b1; idx = 0; held = '0; end
  always @(negedge cs_n) begin
    held  = word;
    idx   = 0;
    sdata = word[15];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      idx = idx + 1;
      #2;
      sdata = (idx < 16) ? held[15 - idx] : 1'b1;
    end
  end
endmodule

module tb_adc_frame_reader;
  localparam int H = 3, S = 2, Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req12 = 1'b0, req10 = 1'b0;
  logic [15:0] w12 = '0, w10 = '0;
  logic rdy12, cs12, sck12, sd12, val12, err12;
  logic rdy10, cs10, sck10, sd10, val10, err10;
  logic [11:0] smp12;
  logic [9:0]  smp10;

  always #5 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(H), .SETUP_CYC(S), .QUIET_CYC(Q), .RES_BITS(12)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req12), .ready_o(rdy12), .cs_n_o(cs12),
    .sclk_o(sck12), .sdata_i(sd12), .sample_o(smp12), .valid_o(val12),
    .frame_err_o(err12));
  adc_frame_reader #(.HALF_DIV(H), .SETUP_CYC(S), .QUIET_CYC(Q), .RES_BITS(10)) dut10 (
    .clk(clk), .rst_n(rst_n), .req_i(req10), .ready_o(rdy10), .cs_n_o(cs10),
    .sclk_o(sck10), .sdata_i(sd10), .sample_o(smp10), .valid_o(val10),
    .frame_err_o(err10));

  tb_adc_model m12 (.cs_n(cs12), .sclk(sck12), .word(w12), .sdata(sd12));
  tb_adc_model m10 (.cs_n(cs10), .sclk(sck10), .word(w10), .sdata(sd10));

  int sel = 12;
  logic s_cs, s_sck, s_val, s_err, s_rdy;
  logic [11:0] s_smp;
  always_comb begin
    s_cs  = (sel == 12) ? cs12  : cs10;
    s_sck = (sel == 12) ? sck12 : sck10;
    s_val = (sel == 12) ? val12 : val10;
    s_err = (sel == 12) ? err12 : err10;
    s_rdy = (sel == 12) ? rdy12 : rdy10;
    s_smp = (sel == 12) ? smp12 : {2'b00, smp10};
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor, sampled at the falling system clock edge
  int cyc = 0, t_csfall = 0, t_edge = 0, t_csrise = 0;
  int setup_meas = 0, falls = 0, bad_half = 0, gap_meas = 0;
  bit have_edge = 0, cs_rose_now = 0;
  logic p_cs = 1'b1, p_sck = 1'b1;
  always @(negedge clk) begin
    cyc++;
    cs_rose_now = 0;
    if (p_cs && !s_cs) begin
      t_csfall = cyc; falls = 0; bad_half = 0; have_edge = 0;
      gap_meas = cyc - t_csrise;
    end
    if (!p_cs && s_cs) begin t_csrise = cyc; cs_rose_now = 1; end
    if (!s_cs && (p_sck != s_sck)) begin
      if (have_edge && (cyc - t_edge != H)) bad_half++;
      if (p_sck && !s_sck) begin
        if (falls == 0) setup_meas = cyc - t_csfall;
        falls++;
      end
      have_edge = 1; t_edge = cyc;
    end
    p_cs = s_cs; p_sck = s_sck;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  function automatic int exp_res(input logic [15:0] w, input int rb);
    int r = 0;
    for (int i = 0; i < rb; i++) r = (r << 1) | int'(w[11 - i]);
    return r;
  endfunction

  function automatic bit exp_err(input logic [15:0] w);
    bit e = 0;
    for (int i = 12; i < 16; i++) e |= w[i];
    return e;
  endfunction

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (s_val) begin got = 1; break; end
    end
  endtask

  task automatic t_reset();
    tick();
    chk(s_cs == 1'b1,  "R1 cs_n", s_cs, 1);
    chk(s_sck == 1'b1, "R1 sclk", s_sck, 1);
    chk(s_val == 1'b0, "R1 valid", s_val, 0);
    chk(s_rdy == 1'b1, "R1 ready", s_rdy, 1);
  endtask

  task automatic t_no_request();
    bit stayed = 1;
    for (int i = 0; i < 30; i++) begin tick(); if (!cs12 || !cs10) stayed = 0; end
    chk(stayed, "R2 idle without request", !stayed, 0);
  endtask

  task automatic t_frame(input int rb, input logic [15:0] w);
    bit got;
    sel = rb;
    if (rb == 12) begin w12 = w; req12 = 1'b1; end
    else          begin w10 = w; req10 = 1'b1; end
    tick();
    chk(s_cs == 1'b0, "R2 cs falls after request", s_cs, 0);
    chk(s_rdy == 1'b0, "R2 ready low in frame", s_rdy, 0);
    req12 = 1'b0; req10 = 1'b0;
    wait_valid(got);
    chk(got, "R9 valid seen", got, 1);
    chk(cs_rose_now, "R9 valid with cs rise", cs_rose_now, 1);
    chk(setup_meas == S, "R3 setup cycles", setup_meas, S);
    chk(falls == 16, "R4 falling edges", falls, 16);
    chk(bad_half == 0, "R4 half period", bad_half, 0);
    chk(int'(s_smp) == exp_res(w, rb), (rb == 12) ? "R6 R5 result" : "R7 R5 result",
        s_smp, exp_res(w, rb));
    chk(s_err == exp_err(w), "R8 framing error", s_err, exp_err(w));
    tick();
    chk(s_val == 1'b0, "R9 valid single cycle", s_val, 0);
    for (int i = 0; i < Q + 4; i++) tick();
    chk(s_rdy == 1'b1, "R2 ready after gap", s_rdy, 1);
  endtask

  task automatic t_back_to_back(input logic [15:0] wa, input logic [15:0] wb);
    bit got;
    sel = 12; w12 = wa; req12 = 1'b1;
    wait_valid(got);
    chk(got && int'(smp12) == exp_res(wa, 12), "R6 first of pair", smp12, exp_res(wa, 12));
    w12 = wb;
    wait_valid(got);
    req12 = 1'b0;
    chk(got && int'(smp12) == exp_res(wb, 12), "R6 second of pair", smp12, exp_res(wb, 12));
    chk(gap_meas >= Q, "R10 quiet gap", gap_meas, Q);
    for (int i = 0; i < Q + 4; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    t_reset();
    t_no_request();
    t_frame(12, 16'h0ABC);
    t_frame(12, 16'h0FFF);
    t_frame(12, 16'h0000);
    t_frame(12, 16'h0801);   // R5 MSB and LSB placement
    t_frame(12, 16'h8123);   // R8 leading bit set
    t_frame(12, 16'h1FFF);   // R8 last leading bit set
    t_frame(10, 16'h0AA7);   // R7 padding bits set, ignored
    t_frame(10, 16'h0554);
    t_frame(10, 16'h4003);   // R7 R8 result zero, error set
    t_back_to_back(16'h0123, 16'h0FED);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule